// File: doc/BRIEF.md
# Multi-Mode Timer/Counter Channel

A single timer/counter channel for a chip's timer subsystem. A small register port with a write strobe and address places the channel in one of six counting modes:

- free counting on the rising, falling or both edges of a prescaled count clock
- gated counting
- quadrature decoding
- up/down counting under a direction pin
- counting that an event edge restarts from zero
- pulse measurement, which reports the high time and the period of one input cycle

The count clock comes from the system clock or from an external clock pin, through a divider of 1, 4, 16, 64, 256 or 1024. The channel never derives a clock: every event is a one-cycle enable in the single `clk` domain. The external clock pin must already be synchronous to `clk`. Two channels can sit side by side with no shared state.

The register port takes a write on every cycle that `reg_valid` and `reg_write` are both high. It never applies back-pressure, and no ready signal exists. Reads are combinational: `reg_rdata` follows `reg_addr` in the same cycle.

Register map (address: contents):
- 0, control: bit 0 enable; bits 3:1 mode (0 free, 1 gated, 2 quadrature, 3 direction, 4 restart, 5 measure; 6 and 7 hold); bits 5:4 edge select (00 rising, 01 falling, 1x both); bit 6 external source; bits 9:7 divider code.
- 1: counter, read/write.
- 2: status, with bit 0 the wrap flag and bit 1 the measure-done flag. Writing 1 to a bit clears it.
- 3: measured high time, read only.
- 4: measured period, read only.
- Other addresses read 0.

The counter stays at its value and the divider restarts while the channel is disabled.

Top module: `tmr_chan`

## Requirements
- R1: After reset, the counter, both measured values, both status flags, `irq_o` and the control register are all 0.
- R2: A write to address 1 loads the counter. The next cycle it is visible on `count_o` and at read address 1. Writes to addresses 3 and 4 change nothing.
- R3: With the internal source, the divider code c (0..5) gives a divide of 4^c, and codes 6 and 7 divide by 1024. Counting starts on the first cycle after enable. The rising count event occurs on the N-th enabled cycle and every N cycles after that, and the falling event on cycle N/2 of each period. For a divide of 1, both events occur every cycle.
- R4: With the external source, only rising edges of `ext_clk_in` (a 0 to 1 change between consecutive cycles) feed the divider. Divider code 0 is treated as code 1 (divide by 4).
- R5: Free mode (mode 0) adds 1 on each rising event for edge select 00, 1 on each falling event for 01, and 1 for each of both events for 1x. With a divide of 1 and both edges, that is 2 per cycle.
- R6: Gated mode (mode 1) adds 1 on a rising event only while `gate_in` is 0.
- R7: Quadrature mode (mode 2) compares {`quad_a`,`quad_b`} each cycle with its value in the cycle before. The changes 00→10, 10→11, 11→01 and 01→00 add 1, and the reverse changes subtract 1. A change of both bits and no change leave the count alone. The divider plays no part.
- R8: Direction mode (mode 3) adds 1 on a rising event when `dir_in` is 1 and subtracts 1 when it is 0.
- R9: Restart mode (mode 4) adds 1 on each rising event. The selected edge of `evt_in` (00 rising, 01 falling, 1x either) sets the counter to 0 in that cycle, taking priority over the increment. Edges that are not selected are ignored.
- R10: Measure mode (mode 5) holds the counter and counts rising events between rising edges of `cap_in`. On each rising edge after the first since enable, it latches the high time and period of the cycle just closed into addresses 3 and 4 and sets the sticky measure-done flag. That flag clears only by writing 1 to status bit 1.
- R11: The counter wraps from 0xFFFF up to 0 and from 0 down to 0xFFFF. Each wrap sets a sticky wrap flag (`ovf_o`, status bit 0) that clears only by writing 1 to status bit 0.
- R12: `irq_o` is high for exactly the one cycle after each wrap or measurement latch.
- R13: While the enable bit is 0, the counter does not change except by a write to address 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_valid | input | 1 | Register access strobe |
| reg_write | input | 1 | Access is a write |
| reg_addr | input | ADDR_W (3) | Register address |
| reg_wdata | input | W (16) | Write data |
| reg_rdata | output | W (16) | Read data for `reg_addr`, combinational |
| ext_clk_in | input | 1 | External count clock, synchronous to `clk` |
| gate_in | input | 1 | Gate; counting allowed while 0 |
| quad_a | input | 1 | Quadrature phase A |
| quad_b | input | 1 | Quadrature phase B |
| dir_in | input | 1 | Count direction, 1 up |
| evt_in | input | 1 | Restart event input |
| cap_in | input | 1 | Signal to measure |
| count_o | output | W (16) | Counter value |
| cap_high_o | output | W (16) | Latched high time |
| cap_period_o | output | W (16) | Latched period |
| ovf_o | output | 1 | Sticky wrap flag |
| cap_done_o | output | 1 | Sticky measure-done flag |
| irq_o | output | 1 | One-cycle event pulse |

## Verification
Free counting is run at divides 1, 4, 16 and 1024. The run lengths are chosen so that rising, falling and both-edge counts give three different results, which separates the edge selects and the prescale codes, including the clamp of codes 6 and 7. The external source is fed known numbers of pulses at code 0 and code 2, which shows that divide-by-1 is replaced by divide-by-4.

Quadrature is driven forward, then backward, then with a two-bit jump, so a wrong direction or a counted jump gives a different total. The restart and measure modes are tried with the ignored edge and with pulse trains whose high time and period all differ, so a swap of the two measured values or an off-by-one period is visible.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [2:0] {
    MD_FREE = 3'd0,
    MD_GATE = 3'd1,
    MD_QUAD = 3'd2,
    MD_DIR  = 3'd3,
    MD_POS  = 3'd4,
    MD_CAPT = 3'd5
  } mode_e;

  localparam int PSC_W   = 3;
  localparam int PSC_MAX = 5;

  typedef struct packed {
    logic [PSC_W-1:0] psc;
    logic             ext;
    logic [1:0]       edge_sel;
    mode_e            mode;
    logic             en;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  localparam int A_CTRL  = 0;
  localparam int A_COUNT = 1;
  localparam int A_STAT  = 2;
  localparam int A_CAPH  = 3;
  localparam int A_CAPP  = 4;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int CODE_W   = 3,
  parameter int MAX_CODE = 5,
  localparam int PS_W    = 2 * MAX_CODE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              ext_sel,
  input  logic [CODE_W-1:0] code,
  input  logic              ext_clk_in,
  output logic              rise_ev,
  output logic              fall_ev
);
  logic              ext_p;
  logic [PS_W-1:0]   ps_cnt;
  logic [CODE_W-1:0] eff;
  logic [PS_W:0]     n_val, n_last, n_half;
  logic              base, at_last, at_half;

  always_comb begin
    eff = (code > CODE_W'(MAX_CODE)) ? CODE_W'(MAX_CODE) : code;
    if (ext_sel && eff == '0) eff = CODE_W'(1);
  end

  assign n_val   = (PS_W+1)'(1) << {eff, 1'b0};
  assign n_last  = n_val - (PS_W+1)'(1);
  assign n_half  = (n_val >> 1) - (PS_W+1)'(1);
  assign base    = ext_sel ? (ext_clk_in & ~ext_p) : 1'b1;
  assign at_last = ({1'b0, ps_cnt} == n_last);
  assign at_half = (eff == '0) ? at_last : ({1'b0, ps_cnt} == n_half);
  assign rise_ev = run & base & at_last;
  assign fall_ev = run & base & at_half;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_p  <= 1'b0;
      ps_cnt <= '0;
    end else begin
      ext_p <= ext_clk_in;
      if (!run)      ps_cnt <= '0;
      else if (base) ps_cnt <= at_last ? '0 : ps_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/tmr_quad.sv
module tmr_quad (
  input  logic clk,
  input  logic rst_n,
  input  logic a,
  input  logic b,
  output logic step_up,
  output logic step_dn
);
  logic a_p, b_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_p <= 1'b0;
      b_p <= 1'b0;
    end else begin
      a_p <= a;
      b_p <= b;
    end
  end

  always_comb begin
    step_up = 1'b0;
    step_dn = 1'b0;
    case ({a_p, b_p, a, b})
      4'b0010, 4'b1011, 4'b1101, 4'b0100: step_up = 1'b1;
      4'b1000, 4'b1110, 4'b0111, 4'b0001: step_dn = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/tmr_capture.sv
module tmr_capture #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         tick,
  input  logic         sig,
  input  logic         clr_done,
  output logic [W-1:0] cap_high,
  output logic [W-1:0] cap_period,
  output logic         done,
  output logic         latch
);
  logic         sig_p, armed, sig_rise;
  logic [W-1:0] acc_hi, acc_per;

  assign sig_rise = sig & ~sig_p;
  assign latch    = run & sig_rise & armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sig_p      <= 1'b0;
      armed      <= 1'b0;
      acc_hi     <= '0;
      acc_per    <= '0;
      cap_high   <= '0;
      cap_period <= '0;
      done       <= 1'b0;
    end else begin
      sig_p <= sig;
      if (!run) begin
        armed   <= 1'b0;
        acc_hi  <= '0;
        acc_per <= '0;
      end else if (sig_rise) begin
        armed   <= 1'b1;
        acc_hi  <= W'(tick);
        acc_per <= W'(tick);
        if (armed) begin
          cap_high   <= acc_hi;
          cap_period <= acc_per;
        end
      end else begin
        acc_per <= acc_per + W'(tick);
        acc_hi  <= acc_hi + W'(tick & sig);
      end
      if (latch)         done <= 1'b1;
      else if (clr_done) done <= 1'b0;
    end
  end
endmodule

// File: rtl/tmr_count.sv
module tmr_count
  import tmr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  mode_e        mode,
  input  logic [1:0]   edge_sel,
  input  logic         rise_ev,
  input  logic         fall_ev,
  input  logic         gate,
  input  logic         dir,
  input  logic         q_up,
  input  logic         q_dn,
  input  logic         evt,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] count,
  output logic         wrap
);
  logic       evt_p, evt_hit, zero, dn;
  logic [1:0] up_amt;
  logic [W:0] sum;

  always_comb begin
    case (edge_sel)
      2'b00:   evt_hit = evt & ~evt_p;
      2'b01:   evt_hit = ~evt & evt_p;
      default: evt_hit = evt ^ evt_p;
    endcase
  end

  always_comb begin
    up_amt = 2'd0;
    dn     = 1'b0;
    zero   = 1'b0;
    if (run) begin
      case (mode)
        MD_FREE: up_amt = {1'b0, rise_ev & (edge_sel != 2'b01)}
                        + {1'b0, fall_ev & (edge_sel != 2'b00)};
        MD_GATE: up_amt = {1'b0, rise_ev & ~gate};
        MD_QUAD: begin
          up_amt = {1'b0, q_up};
          dn     = q_dn;
        end
        MD_DIR: begin
          up_amt = {1'b0, rise_ev & dir};
          dn     = rise_ev & ~dir;
        end
        MD_POS: begin
          up_amt = {1'b0, rise_ev};
          zero   = evt_hit;
        end
        default: ;
      endcase
    end
  end

  assign sum  = {1'b0, count} + (W+1)'(up_amt);
  assign wrap = ~load & ~zero & ((dn & (count == '0)) | sum[W]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_p <= 1'b0;
      count <= '0;
    end else begin
      evt_p <= evt;
      if (load)      count <= load_val;
      else if (zero) count <= '0;
      else if (dn)   count <= count - 1'b1;
      else           count <= sum[W-1:0];
    end
  end
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
  import tmr_pkg::*;
#(
  parameter int W      = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_valid,
  input  logic              reg_write,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [W-1:0]      reg_wdata,
  output logic [W-1:0]      reg_rdata,
  input  logic              ext_clk_in,
  input  logic              gate_in,
  input  logic              quad_a,
  input  logic              quad_b,
  input  logic              dir_in,
  input  logic              evt_in,
  input  logic              cap_in,
  output logic [W-1:0]      count_o,
  output logic [W-1:0]      cap_high_o,
  output logic [W-1:0]      cap_period_o,
  output logic              ovf_o,
  output logic              cap_done_o,
  output logic              irq_o
);
  ctrl_t      ctrl_q;
  logic       wr, wr_ctrl, load, stat_wr, ovf_clr, cap_clr;
  logic       ctl_en;
  mode_e      ctl_mode;
  logic [1:0] ctl_edge;
  logic       rise_ev, fall_ev, q_up, q_dn, wrap, cap_latch, cap_run;
  logic       ovf_q, irq_q;

  assign wr       = reg_valid & reg_write;
  assign wr_ctrl  = wr & (reg_addr == ADDR_W'(A_CTRL));
  assign load     = wr & (reg_addr == ADDR_W'(A_COUNT));
  assign stat_wr  = wr & (reg_addr == ADDR_W'(A_STAT));
  assign ovf_clr  = stat_wr & reg_wdata[0];
  assign cap_clr  = stat_wr & reg_wdata[1];
  assign ctl_en   = ctrl_q.en;
  assign ctl_mode = ctrl_q.mode;
  assign ctl_edge = ctrl_q.edge_sel;
  assign cap_run  = ctl_en & (ctl_mode == MD_CAPT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      ovf_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
      if (wrap)         ovf_q <= 1'b1;
      else if (ovf_clr) ovf_q <= 1'b0;
      irq_q <= wrap | cap_latch;
    end
  end

  tmr_prescale #(.CODE_W(PSC_W), .MAX_CODE(PSC_MAX)) u_psc (
    .clk(clk), .rst_n(rst_n), .run(ctl_en), .ext_sel(ctrl_q.ext),
    .code(ctrl_q.psc), .ext_clk_in(ext_clk_in),
    .rise_ev(rise_ev), .fall_ev(fall_ev)
  );

  tmr_quad u_quad (
    .clk(clk), .rst_n(rst_n), .a(quad_a), .b(quad_b),
    .step_up(q_up), .step_dn(q_dn)
  );

  tmr_count #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(ctl_en), .mode(ctl_mode),
    .edge_sel(ctl_edge), .rise_ev(rise_ev), .fall_ev(fall_ev),
    .gate(gate_in), .dir(dir_in), .q_up(q_up), .q_dn(q_dn),
    .evt(evt_in), .load(load), .load_val(reg_wdata),
    .count(count_o), .wrap(wrap)
  );

  tmr_capture #(.W(W)) u_cap (
    .clk(clk), .rst_n(rst_n), .run(cap_run), .tick(rise_ev),
    .sig(cap_in), .clr_done(cap_clr),
    .cap_high(cap_high_o), .cap_period(cap_period_o),
    .done(cap_done_o), .latch(cap_latch)
  );

  always_comb begin
    case (reg_addr)
      ADDR_W'(A_CTRL):  reg_rdata = W'(ctrl_q);
      ADDR_W'(A_COUNT): reg_rdata = count_o;
      ADDR_W'(A_STAT):  reg_rdata = W'({cap_done_o, ovf_q});
      ADDR_W'(A_CAPH):  reg_rdata = cap_high_o;
      ADDR_W'(A_CAPP):  reg_rdata = cap_period_o;
      default:          reg_rdata = '0;
    endcase
  end

  assign ovf_o = ovf_q;
  assign irq_o = irq_q;
endmodule

// File: rtl/tmr_chan_chk.sv
module tmr_chan_chk
  import tmr_pkg::*;
#(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         en,
  input logic [2:0]   mode,
  input logic [1:0]   edge_sel,
  input logic         load,
  input logic         gate_in,
  input logic         evt_in,
  input logic [W-1:0] count,
  input logic         ovf,
  input logic         ovf_clr,
  input logic         cap_done,
  input logic         cap_clr
);
  AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n) (!en && !load) |=> $stable(count)); // R13
  AST_FREE_STEP: assert property (@(posedge clk) disable iff (!rst_n) (en && mode == MD_FREE && !load) |=> ((count - $past(count)) <= W'(2))); // R5
  AST_GATE_BLOCK: assert property (@(posedge clk) disable iff (!rst_n) (en && mode == MD_GATE && gate_in && !load) |=> $stable(count)); // R6
  AST_DIR_STEP: assert property (@(posedge clk) disable iff (!rst_n) (en && mode == MD_DIR && !load) |=> (count == $past(count) || count == $past(count) + W'(1) || count == $past(count) - W'(1))); // R8
  AST_POS_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (en && mode == MD_POS && edge_sel == 2'b00 && $rose(evt_in) && !load) |=> (count == '0)); // R9
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (ovf && !ovf_clr) |=> ovf); // R11
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (cap_done && !cap_clr) |=> cap_done); // R10
endmodule

bind tmr_chan tmr_chan_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(ctl_en), .mode(ctl_mode), .edge_sel(ctl_edge),
  .load(load), .gate_in(gate_in), .evt_in(evt_in), .count(count_o),
  .ovf(ovf_o), .ovf_clr(ovf_clr), .cap_done(cap_done_o), .cap_clr(cap_clr)
);

// File: tb/tmr_chan_bench.sv
module tmr_chan_bench;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         reg_valid = 1'b0, reg_write = 1'b0;
  logic [2:0]   reg_addr = '0;
  logic [W-1:0] reg_wdata = '0;
  logic [W-1:0] reg_rdata;
  logic         ext_clk_in = 0, gate_in = 0, quad_a = 0, quad_b = 0;
  logic         dir_in = 0, evt_in = 0, cap_in = 0;
  logic [W-1:0] count_o, cap_high_o, cap_period_o;
  logic         ovf_o, cap_done_o, irq_o;

  int n_chk = 0, n_bad = 0;
  bit mon_on = 0;
  int n_popped = 0;
  logic [31:0] exp_q[$];

  always #4 clk = ~clk;

  tmr_chan u_tmr_chan (
    .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_write(reg_write),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ext_clk_in(ext_clk_in), .gate_in(gate_in), .quad_a(quad_a), .quad_b(quad_b),
    .dir_in(dir_in), .evt_in(evt_in), .cap_in(cap_in), .count_o(count_o),
    .cap_high_o(cap_high_o), .cap_period_o(cap_period_o), .ovf_o(ovf_o),
    .cap_done_o(cap_done_o), .irq_o(irq_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int addr, input logic [W-1:0] data);
    @(negedge clk);
    reg_valid = 1; reg_write = 1; reg_addr = 3'(addr); reg_wdata = data;
    @(negedge clk);
    reg_valid = 0; reg_write = 0;
  endtask

  task automatic rd(input int addr, output logic [W-1:0] data);
    reg_addr = 3'(addr);
    #1 data = reg_rdata;
  endtask

  // control word: psc[9:7] ext[6] edge[5:4] mode[3:1] en[0]
  function automatic logic [W-1:0] cfg(input int mode, input int edg, input int ext, input int psc);
    return W'((psc << 7) | (ext << 6) | (edg << 4) | (mode << 1) | 1);
  endfunction

  task automatic run_cnt(input string req, input logic [W-1:0] start, input logic [W-1:0] c,
                         input int k, input logic [W-1:0] exp);
    wr(1, start);
    wr(0, c);
    repeat (k) @(negedge clk);
    check(req, count_o, exp);
    wr(0, 0);
  endtask

  task automatic ext_pulses(input int n);
    for (int i = 0; i < n; i++) begin
      ext_clk_in = 1; @(negedge clk);
      ext_clk_in = 0; @(negedge clk);
    end
  endtask

  task automatic qset(input logic a, input logic b);
    quad_a = a; quad_b = b; @(negedge clk);
  endtask

  // driver: one cap_in cycle; queues the result the NEXT rise will latch
  task automatic cap_train(input int hs[], input int ls[], input int div);
    for (int i = 0; i <= hs.size(); i++) begin
      if (i > 0) exp_q.push_back({16'(hs[i-1] / div), 16'((hs[i-1] + ls[i-1]) / div)});
      cap_in = 1;
      if (i == hs.size()) begin
        repeat (2) @(negedge clk);
        cap_in = 0;
        repeat (4) @(negedge clk);
      end else begin
        repeat (hs[i]) @(negedge clk);
        cap_in = 0;
        repeat (ls[i]) @(negedge clk);
      end
    end
  endtask

  // monitor: each latch shows as an irq pulse with the new values
  always @(negedge clk) begin
    if (rst_n && mon_on && irq_o) begin
      if (exp_q.size() == 0) begin
        check("R10 unexpected latch", 32'(cap_period_o), 32'hFFFF_FFFF);
      end else begin
        logic [31:0] e;
        e = exp_q.pop_front();
        n_popped++;
        check("R10 high time", 32'(cap_high_o), 32'(e[31:16]));
        check("R10 period", 32'(cap_period_o), 32'(e[15:0]));
      end
    end
  end

  task automatic finish_run;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [W-1:0] v;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 count", 32'(count_o), 0);
    check("R1 flags", 32'({ovf_o, cap_done_o, irq_o}), 0);
    check("R1 capture", 32'({cap_high_o, cap_period_o}), 0);
    rd(0, v); check("R1 ctrl", 32'(v), 0);

    // R5/R3 free mode, divide 4, 42 cycles: rise 10, fall 11, both 21
    run_cnt("R5 rise div4", 0, cfg(0, 0, 0, 1), 42, 10);
    run_cnt("R5 fall div4", 0, cfg(0, 1, 0, 1), 42, 11);
    run_cnt("R5 both div4", 0, cfg(0, 2, 0, 1), 42, 21);
    run_cnt("R5 both div1", 0, cfg(0, 3, 0, 0), 10, 20);
    run_cnt("R3 div16", 0, cfg(0, 0, 0, 2), 64, 4);
    run_cnt("R3 div1024", 0, cfg(0, 0, 0, 5), 2048, 2);
    run_cnt("R3 code7 div1024", 0, cfg(0, 0, 0, 7), 1024, 1);

    // R4 external source: code 0 acts as divide 4
    wr(1, 0); wr(0, cfg(0, 0, 1, 0));
    ext_pulses(8);
    check("R4 ext code0", 32'(count_o), 2);
    wr(0, 0);
    wr(1, 0); wr(0, cfg(0, 0, 1, 2));
    ext_pulses(16);
    check("R4 ext code2", 32'(count_o), 1);
    wr(0, 0);

    // R6 gate mode, divide 1: 5 open + 3 open = 8
    wr(1, 0); wr(0, cfg(1, 0, 0, 0));
    repeat (5) @(negedge clk);
    gate_in = 1; repeat (7) @(negedge clk);
    gate_in = 0; repeat (3) @(negedge clk);
    check("R6 gated count", 32'(count_o), 8);
    wr(0, 0);

    // R8 direction: 5 + 6 - 10 = 1
    dir_in = 1;
    wr(1, 5); wr(0, cfg(3, 0, 0, 0));
    repeat (6) @(negedge clk);
    dir_in = 0; repeat (10) @(negedge clk);
    check("R8 up/down", 32'(count_o), 1);
    wr(0, 0);

    // R11/R12 underflow: 2 -> 1 -> 0 -> FFFF (wrap) -> FFFE
    wr(1, 2); wr(0, cfg(3, 0, 0, 0));
    repeat (3) @(negedge clk);
    check("R12 irq after wrap", 32'(irq_o), 1);
    @(negedge clk);
    check("R12 irq one cycle", 32'(irq_o), 0);
    check("R11 underflow value", 32'(count_o), 16'hFFFE);
    wr(0, 0);
    rd(2, v); check("R11 wrap flag set", 32'(v[0]), 1);
    wr(2, 1);
    check("R11 wrap flag cleared", 32'(ovf_o), 0);

    // R11 overflow upward
    run_cnt("R11 overflow value", 16'hFFFE, cfg(0, 0, 0, 0), 3, 1);
    check("R11 overflow flag", 32'(ovf_o), 1);
    wr(2, 1);

    // R7 quadrature: 8 up, 3 down, one jump ignored
    wr(1, 0); wr(0, cfg(2, 0, 0, 0));
    for (int r = 0; r < 2; r++) begin
      qset(1, 0); qset(1, 1); qset(0, 1); qset(0, 0);
    end
    qset(0, 1); qset(1, 1); qset(1, 0);
    qset(0, 1);
    check("R7 quadrature", 32'(count_o), 5);
    wr(0, 0);
    qset(0, 0);

    // R9 restart on rising edge; falling edge ignored
    wr(1, 0); wr(0, cfg(4, 0, 0, 0));
    repeat (10) @(negedge clk);
    check("R9 counting", 32'(count_o), 10);
    evt_in = 1; @(negedge clk);
    check("R9 rising restart", 32'(count_o), 0);
    repeat (4) @(negedge clk);
    evt_in = 0; repeat (2) @(negedge clk);
    check("R9 falling ignored", 32'(count_o), 6);
    wr(0, 0);
    run_cnt("R9 fall select pre", 0, cfg(4, 1, 0, 0), 3, 3);
    wr(1, 0); wr(0, cfg(4, 1, 0, 0));
    evt_in = 1; repeat (2) @(negedge clk);
    check("R9 rising ignored", 32'(count_o), 2);
    evt_in = 0; @(negedge clk);
    check("R9 falling restart", 32'(count_o), 0);
    wr(0, 0);

    // R10 measure, divide 1 then divide 4
    mon_on = 1;
    wr(1, 16'h0077); wr(0, cfg(5, 0, 0, 0));
    cap_train('{3, 7, 1}, '{5, 2, 1}, 1);
    check("R10 counter held", 32'(count_o), 16'h0077);
    rd(2, v); check("R10 done flag", 32'(v[1]), 1);
    rd(3, v); check("R2 read high", 32'(v), 1);
    rd(4, v); check("R2 read period", 32'(v), 2);
    wr(3, 16'hABCD); wr(4, 16'h1234);
    rd(3, v); check("R2 ro high", 32'(v), 1);
    rd(4, v); check("R2 ro period", 32'(v), 2);
    wr(2, 2);
    check("R10 done cleared", 32'(cap_done_o), 0);
    wr(0, 0);
    wr(0, cfg(5, 0, 0, 1));
    cap_train('{8, 4}, '{12, 8}, 4);
    wr(0, 0);
    check("R10 all latches seen", 32'(n_popped), 5);
    check("R10 queue empty", 32'(exp_q.size()), 0);
    mon_on = 0;

    // R13 hold while disabled, R2 load readback
    wr(0, cfg(0, 0, 0, 0) & ~W'(1));
    wr(1, 16'h1234);
    repeat (20) @(negedge clk);
    check("R13 held while off", 32'(count_o), 16'h1234);
    rd(1, v); check("R2 count readback", 32'(v), 16'h1234);

    finish_run();
  end
endmodule